// File: doc/BRIEF.md
# Host-Facing Parallel Slave Port

This block lets an external microprocessor treat an 8-bit register inside the chip as a peripheral on its own bus. The external host uses three active-low strobes: chip select, read and write. It also uses a data bus that is split here into an input, an output and an output enable. The local processor works on the other side of the block. It writes an outbound latch that the host reads, and it reads an inbound latch that the host writes. Status flags show when either latch holds data that has not yet been consumed.

The host strobes are asynchronous to the local clock. Each one passes through a synchroniser. Transfer start and end are found by comparing the synchronised level with a copy delayed by one cycle. Flags change only when a host strobe ends. A local enable input gates the whole host side: while it is low, the strobes have no effect.

Top module: `host_slave_port`

## Requirements
- R1: After reset, all of the following are 0: the inbound latch, the outbound latch, the bus output enable, and the flags `in_full`, `out_full`, `in_overrun` and `port_event`.
- R2: While `port_en` is 0, host strobes do not change the inbound latch or any flag, and `ext_data_oe` stays 0.
- R3: A host write starts when synchronised chip select and write are both low. It ends when either one goes high. At the end, the inbound latch takes the last bus value sampled during the write, and `in_full` and `port_event` are set.
- R4: A one-cycle `loc_in_ack` clears `in_full`. If a write end happens in the same cycle, `in_full` stays set.
- R5: `ext_data_oe` is 1 exactly while `port_en` is 1 and synchronised chip select and read are both low.
- R6: `ext_data_o` always shows the outbound latch. A local write updates it on the next clock edge, and this also applies while a host read is in progress.
- R7: `loc_out_we` loads the outbound latch and sets `out_full` on the next edge. The end of a host read clears `out_full`. If both happen in the same cycle, the set wins.
- R8: If a write ends while `in_full` is set and no `loc_in_ack` arrives in the same cycle, `in_overrun` is set and the new data still replaces the latch. `loc_overrun_clr` clears `in_overrun`. If both happen in the same cycle, the set wins.
- R9: The end of a host read also sets `port_event`. `port_event` stays set until `loc_event_clr`. If a set and a clear happen in the same cycle, the set wins.
- R10: With two synchroniser stages, a flag set by a strobe release becomes visible after the third rising clock edge that follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | Enables the host side |
| ext_cs_n | input | 1 | Host chip select, active low |
| ext_rd_n | input | 1 | Host read strobe, active low |
| ext_wr_n | input | 1 | Host write strobe, active low |
| ext_data_i | input | DATA_W | Bus value driven by the host |
| ext_data_o | output | DATA_W | Outbound latch value for the bus |
| ext_data_oe | output | 1 | Bus drive enable |
| loc_out_we | input | 1 | Local write to the outbound latch |
| loc_out_data | input | DATA_W | Local write data |
| loc_in_ack | input | 1 | Local read of the inbound latch; clears `in_full` |
| loc_in_data | output | DATA_W | Inbound latch value |
| loc_event_clr | input | 1 | Clears `port_event` |
| loc_overrun_clr | input | 1 | Clears `in_overrun` |
| in_full | output | 1 | Inbound latch holds unread data |
| out_full | output | 1 | Outbound latch not yet read by host |
| in_overrun | output | 1 | A host write replaced unread data |
| port_event | output | 1 | A host transfer has ended |

## Verification
The bench uses the defaults `DATA_W`=8 and `SYNC_STAGES`=2. With two stages, the fixed three-edge latency from strobe release to flag can be checked with a model that tracks each edge, and directed checks probe that latency. Eight data bits are enough to drive distinct patterns on every transfer. These patterns expose wrong captures, overrun replacement, and a local write that lands in the middle of a read. Same-cycle collisions, such as an acknowledge at a write end or a local write at a read end, are placed at the edges the model predicts.

// File: rtl/host_slave_port.sv
module host_slave_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              ext_cs_n,
  input  logic              ext_rd_n,
  input  logic              ext_wr_n,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe,
  input  logic              loc_out_we,
  input  logic [DATA_W-1:0] loc_out_data,
  input  logic              loc_in_ack,
  output logic [DATA_W-1:0] loc_in_data,
  input  logic              loc_event_clr,
  input  logic              loc_overrun_clr,
  output logic              in_full,
  output logic              out_full,
  output logic              in_overrun,
  output logic              port_event
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cs_sh, rd_sh, wr_sh;
  logic rd_prev, wr_prev;
  logic [DATA_W-1:0] wr_hold, in_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '1;
      rd_sh <= '1;
      wr_sh <= '1;
    end else begin
      cs_sh <= {cs_sh[LAST-1:0], ext_cs_n};
      rd_sh <= {rd_sh[LAST-1:0], ext_rd_n};
      wr_sh <= {wr_sh[LAST-1:0], ext_wr_n};
    end
  end

  wire rd_on   = port_en & ~cs_sh[LAST] & ~rd_sh[LAST];
  wire wr_on   = port_en & ~cs_sh[LAST] & ~wr_sh[LAST];
  wire rd_done = port_en & rd_prev & ~rd_on;
  wire wr_done = port_en & wr_prev & ~wr_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev    <= 1'b0;
      wr_prev    <= 1'b0;
      wr_hold    <= '0;
      in_q       <= '0;
      out_q      <= '0;
      in_full    <= 1'b0;
      out_full   <= 1'b0;
      in_overrun <= 1'b0;
      port_event <= 1'b0;
    end else begin
      rd_prev <= rd_on;
      wr_prev <= wr_on;
      if (wr_on) wr_hold <= ext_data_i;
      if (wr_done) in_q <= wr_hold;
      if (loc_out_we) out_q <= loc_out_data;

      if (wr_done) in_full <= 1'b1;
      else if (loc_in_ack) in_full <= 1'b0;

      if (loc_out_we) out_full <= 1'b1;
      else if (rd_done) out_full <= 1'b0;

      if (wr_done && in_full && !loc_in_ack) in_overrun <= 1'b1;
      else if (loc_overrun_clr) in_overrun <= 1'b0;

      if (wr_done || rd_done) port_event <= 1'b1;
      else if (loc_event_clr) port_event <= 1'b0;
    end
  end

  assign ext_data_oe = rd_on;
  assign ext_data_o  = out_q;
  assign loc_in_data = in_q;

endmodule

// File: rtl/host_slave_port_chk.sv
module host_slave_port_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic ext_data_oe,
  input logic loc_out_we,
  input logic loc_event_clr,
  input logic in_full,
  input logic out_full,
  input logic in_overrun,
  input logic port_event
);

  assert_oe_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_data_oe |-> port_en);

  assert_full_raises_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_full) |-> port_event);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !$past(port_en)) |-> !$rose(in_full));

  assert_overrun_with_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_overrun) |-> in_full);

  assert_local_write_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loc_out_we |=> out_full);

  assert_event_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_event && !loc_event_clr) |=> port_event);

endmodule

bind host_slave_port host_slave_port_chk chk_i (.*);

// File: tb/host_slave_port_tb_top.sv
`timescale 1ns/1ps
module host_slave_port_tb_top;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, port_en = 0;
  logic ext_cs_n = 1, ext_rd_n = 1, ext_wr_n = 1;
  logic [W-1:0] ext_data_i = '0, loc_out_data = '0;
  logic loc_out_we = 0, loc_in_ack = 0, loc_event_clr = 0, loc_overrun_clr = 0;
  logic [W-1:0] ext_data_o, loc_in_data;
  logic ext_data_oe, in_full, out_full, in_overrun, port_event;

  always #2.5 clk = ~clk;

  host_slave_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (.*);

  int compared = 0, mismatched = 0;
  bit done = 0;

  // behavioural reference
  bit m_cs[2], m_rd[2], m_wr[2];
  bit m_rp, m_wp, m_ibf, m_obf, m_ovf, m_evt;
  int m_hold, m_in, m_out;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = '{1, 1}; m_rd = '{1, 1}; m_wr = '{1, 1};
      m_rp = 0; m_wp = 0; m_ibf = 0; m_obf = 0; m_ovf = 0; m_evt = 0;
      m_hold = 0; m_in = 0; m_out = 0;
    end else begin
      bit ron, won, rdn, wdn, old_ibf;
      ron = port_en && !m_cs[1] && !m_rd[1];
      won = port_en && !m_cs[1] && !m_wr[1];
      rdn = port_en && m_rp && !ron;
      wdn = port_en && m_wp && !won;
      old_ibf = m_ibf;
      if (wdn) m_in = m_hold;
      if (won) m_hold = ext_data_i;
      if (loc_out_we) m_out = loc_out_data;
      if (wdn) m_ibf = 1; else if (loc_in_ack) m_ibf = 0;
      if (loc_out_we) m_obf = 1; else if (rdn) m_obf = 0;
      if (wdn && old_ibf && !loc_in_ack) m_ovf = 1; else if (loc_overrun_clr) m_ovf = 0;
      if (wdn || rdn) m_evt = 1; else if (loc_event_clr) m_evt = 0;
      m_rp = ron; m_wp = won;
      m_cs[1] = m_cs[0]; m_cs[0] = ext_cs_n;
      m_rd[1] = m_rd[0]; m_rd[0] = ext_rd_n;
      m_wr[1] = m_wr[0]; m_wr[0] = ext_wr_n;
    end
    #1;
    if (rst_n) begin
      chk("R5", "oe", ext_data_oe, port_en && !m_cs[1] && !m_rd[1]);
      chk("R6", "data_o", ext_data_o, m_out);
      chk("R3", "in_data", loc_in_data, m_in);
      chk("R4", "in_full", in_full, m_ibf);
      chk("R7", "out_full", out_full, m_obf);
      chk("R8", "overrun", in_overrun, m_ovf);
      chk("R9", "event", port_event, m_evt);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [W-1:0] d, input bit end_by_cs);
    ext_data_i = d; ext_cs_n = 0; ext_wr_n = 0;
    cyc(5);
    if (end_by_cs) ext_cs_n = 1; else ext_wr_n = 1;
    cyc(1);
    ext_cs_n = 1; ext_wr_n = 1;
    cyc(5);
  endtask

  task automatic pulse_ack();   loc_in_ack = 1; cyc(1); loc_in_ack = 0; endtask
  task automatic pulse_evt();   loc_event_clr = 1; cyc(1); loc_event_clr = 0; endtask
  task automatic local_write(input logic [W-1:0] d);
    loc_out_data = d; loc_out_we = 1; cyc(1); loc_out_we = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1", "reset flags", {in_full, out_full, in_overrun, port_event, ext_data_oe}, 0);
    chk("R1", "reset latches", {loc_in_data, ext_data_o}, 0);
    // R2 disabled: strobes ignored
    host_write(8'hA5, 0);
    ext_cs_n = 0; ext_rd_n = 0; cyc(4);
    chk("R2", "oe while disabled", ext_data_oe, 0);
    ext_cs_n = 1; ext_rd_n = 1; cyc(4);
    chk("R2", "flags while disabled", {in_full, port_event, loc_in_data}, 0);
    port_en = 1; cyc(2);
    // R3 + R10 latency of write end
    ext_data_i = 8'h3C; ext_cs_n = 0; ext_wr_n = 0; cyc(5);
    ext_wr_n = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10", "in_full before third edge", in_full, 0);
    @(posedge clk); #1;
    chk("R10", "in_full after third edge", in_full, 1);
    chk("R3", "captured data", loc_in_data, 8'h3C);
    cyc(3); ext_cs_n = 1; cyc(3);
    pulse_evt();
    // R8 overrun: second write before ack
    host_write(8'h5A, 1);
    chk("R8", "overrun set", in_overrun, 1);
    chk("R8", "new data replaces", loc_in_data, 8'h5A);
    loc_overrun_clr = 1; cyc(1); loc_overrun_clr = 0;
    chk("R8", "overrun cleared", in_overrun, 0);
    pulse_ack();
    chk("R4", "ack clears full", in_full, 0);
    pulse_evt();
    chk("R9", "event cleared", port_event, 0);
    // R4 ack colliding with write end: write data, then ack timed at end edge
    host_write(8'h11, 0);
    ext_data_i = 8'h22; ext_cs_n = 0; ext_wr_n = 0; cyc(5);
    ext_cs_n = 1; ext_wr_n = 1;
    cyc(2); loc_in_ack = 1; cyc(1); loc_in_ack = 0;
    cyc(1);
    chk("R4", "full kept on collision", in_full, 1);
    chk("R8", "no overrun when acked", in_overrun, 0);
    pulse_ack(); pulse_evt();
    // R5/R6/R7 host read with local write in progress
    local_write(8'h77);
    chk("R7", "out_full set", out_full, 1);
    ext_cs_n = 0; ext_rd_n = 0; cyc(3);
    chk("R5", "oe during read", ext_data_oe, 1);
    chk("R6", "bus shows latch", ext_data_o, 8'h77);
    local_write(8'h99);
    chk("R6", "mid-read update", ext_data_o, 8'h99);
    ext_rd_n = 1; cyc(4);
    chk("R5", "oe released", ext_data_oe, 0);
    chk("R7", "out_full cleared", out_full, 0);
    chk("R9", "event on read end", port_event, 1);
    ext_cs_n = 1; cyc(2);
    // R7/R9 collisions: local write and event clear at read end edge
    local_write(8'h42);
    ext_cs_n = 0; ext_rd_n = 0; cyc(4);
    ext_cs_n = 1; ext_rd_n = 1;
    cyc(2); loc_out_data = 8'h43; loc_out_we = 1; loc_event_clr = 1; cyc(1);
    loc_out_we = 0; loc_event_clr = 0;
    chk("R7", "set wins over read end", out_full, 1);
    chk("R9", "set wins over clear", port_event, 1);
    // R2 enable drop mid-write
    host_write(8'hF0, 0);
    pulse_ack(); pulse_evt();
    ext_data_i = 8'h0F; ext_cs_n = 0; ext_wr_n = 0; cyc(4);
    port_en = 0; cyc(2); ext_cs_n = 1; ext_wr_n = 1; cyc(5);
    chk("R2", "disabled write ignored", in_full, 0);
    port_en = 1; cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule